// File: doc/BRIEF.md
# Programmable LED Status Indicator

This block drives one LED pin for a network controller. A 16-bit control register picks which network status conditions light the LED. Each enabled condition is ORed into a single "LED active" result. Three of the conditions are short events: Magic Packet detection, receive activity that matched an address, and transmit activity. A retriggerable pulse stretcher can lengthen these events so that they stay visible to the eye. A polarity bit chooses whether the active state drives the pin high or low. A disable bit overrides everything and forces the pin to its inactive level.

The stretched OR result can be read back as bit 15 of the register. This lets software see the condition before polarity and disable are applied. A hard-reset strobe loads the default control value. A soft-reset strobe and a stop condition leave the control fields unchanged, so the LED setup survives a soft restart. The stretch length is set by the parameter `STRETCH_CYCLES` (default 16).

Top module: `led_status_ind`

## Requirements
- R1: Disable (bit 13) = 1 forces `led_pin` to the inactive level, which is the complement of the polarity bit. This takes effect on the first clock edge after the register holds the disable bit. It overrides every other field.
- R2: Polarity (bit 14) = 1 makes an active result drive `led_pin` high. Polarity = 0 makes an active result drive it low. The inactive level is always the complement of the active level.
- R3: Each enable bit adds one source to the OR:
  - bit 12: `st_100m`.
  - bit 9: `st_mp_mode` AND `st_mp_det`.
  - bit 6: `st_link`.
  - bit 5: `st_rx_match`.
  - bit 4: `st_tx`.
- R4: The full-duplex enable (bit 8) contributes 1 only when `st_link` and `st_fdx` are both 1. Otherwise it contributes 0.
- R5: With stretch enable (bit 7) = 1, a rising edge of any enabled event term (bit 9, bit 5 or bit 4 term) reloads a counter to `STRETCH_CYCLES`. The counter decrements once per cycle. The result stays active while the raw OR is 1 or the counter is nonzero. Level terms (bits 12, 8, 6) never reload the counter.
- R6: With stretch enable = 0, the raw OR passes through unstretched and the counter is held at zero.
- R7: Read bit 15 is read-only. It shows the stretched OR result of the current cycle, before polarity and disable are applied.
- R8: Bits 11, 10 and 3..0 read as zero and ignore writes. Writes to bit 15 are ignored.
- R9: A hard reset (`hrst`) loads control value 0x0080: only stretch enable is set. It also clears the counter and drives `led_pin` to 1, the inactive level for polarity 0.
- R10: `srst` and `stop` leave all control fields and the LED behaviour unchanged.
- R11: A write with `reg_we` = 1 is accepted in any cycle. It is visible on `reg_rdata` in the next cycle.
- R12: `led_pin` is registered. Its value after a clock edge is computed from the register contents and status inputs present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst | input | 1 | Hard reset strobe, synchronous, active high |
| srst | input | 1 | Soft reset strobe (no effect on this block) |
| stop | input | 1 | Stop condition (no effect on this block) |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data, bit 15 = status |
| st_100m | input | 1 | 100 Mbps mode active |
| st_mp_mode | input | 1 | Magic Packet mode enabled |
| st_mp_det | input | 1 | Magic Packet frame detected |
| st_link | input | 1 | Link pass |
| st_fdx | input | 1 | Full-duplex enabled |
| st_rx_match | input | 1 | Address-matched receive activity |
| st_tx | input | 1 | Transmit activity |
| led_pin | output | 1 | LED drive level |

## Verification
Each result is due at a fixed cycle:
- A register write shows on `reg_rdata` in the cycle after its write edge.
- The status bit is combinational, so it reflects the inputs in the same cycle.
- `led_pin` trails the stretched result by one edge.
- After an event edge, the stretch counter holds the result active for `STRETCH_CYCLES` more cycles.

The reference model in the bench updates on the same edge as the design, from the values present before that edge. Both outputs are compared one nanosecond after every rising edge. Inputs change only on falling edges, so every comparison lands on the cycle in which the value is due.

// File: rtl/led_ind_pkg.sv
package led_ind_pkg;

  localparam int REG_W = 16;
  localparam int NUM_EV = 3;
  localparam logic [REG_W-1:0] WR_MASK = 16'h73F0;

  typedef struct packed {
    logic pol;
    logic dis;
    logic spd_en;
    logic mp_en;
    logic fdx_en;
    logic pse;
    logic lnk_en;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef struct packed {
    logic spd;
    logic mp_mode;
    logic mp_det;
    logic link;
    logic fdx;
    logic rx_match;
    logic tx;
  } stat_in_t;

  localparam ctrl_t CTRL_RST = '{pol: 1'b0, dis: 1'b0, spd_en: 1'b0, mp_en: 1'b0,
                                 fdx_en: 1'b0, pse: 1'b1, lnk_en: 1'b0,
                                 rx_en: 1'b0, tx_en: 1'b0};

  function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.pol    = w[14];
    c.dis    = w[13];
    c.spd_en = w[12];
    c.mp_en  = w[9];
    c.fdx_en = w[8];
    c.pse    = w[7];
    c.lnk_en = w[6];
    c.rx_en  = w[5];
    c.tx_en  = w[4];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c, input logic stat);
    return {stat, c.pol, c.dis, c.spd_en, 2'b00, c.mp_en, c.fdx_en,
            c.pse, c.lnk_en, c.rx_en, c.tx_en, 4'b0000};
  endfunction

  // Level-type sources: held conditions, never reload the stretcher.
  function automatic logic level_or(input ctrl_t c, input stat_in_t s);
    return (c.spd_en & s.spd) | (c.fdx_en & s.link & s.fdx) | (c.lnk_en & s.link);
  endfunction

  // Event-type sources, already masked by their enables.
  function automatic logic [NUM_EV-1:0] event_terms(input ctrl_t c, input stat_in_t s);
    return {c.mp_en & s.mp_mode & s.mp_det, c.rx_en & s.rx_match, c.tx_en & s.tx};
  endfunction

  function automatic logic pin_level(input logic dis, input logic pol, input logic active);
    return (active & ~dis) ? pol : ~pol;
  endfunction

endpackage

// File: rtl/led_ind_regs.sv
module led_ind_regs
  import led_ind_pkg::*;
(
  input  logic             clk,
  input  logic             hrst,
  input  logic             srst,
  input  logic             stop,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl_q
);

  always_ff @(posedge clk) begin
    if (hrst)    ctrl_q <= CTRL_RST;
    else if (we) ctrl_q <= word_to_ctrl(wdata);
  end

  a_r9_hard_reset_value: assert property (@(posedge clk)
    hrst |=> (ctrl_q == CTRL_RST));

  a_r10_soft_reset_keeps: assert property (@(posedge clk) disable iff (hrst)
    ((srst || stop) && !we) |=> $stable(ctrl_q));

  a_r11_write_lands: assert property (@(posedge clk) disable iff (hrst)
    we |=> (ctrl_q == word_to_ctrl($past(wdata))));

endmodule

// File: rtl/led_ind_src.sv
module led_ind_src
  import led_ind_pkg::*;
#(
  parameter int STRETCH_CYCLES = 16
)(
  input  logic     clk,
  input  logic     hrst,
  input  ctrl_t    ctrl,
  input  stat_in_t stat,
  output logic     raw_or,
  output logic     ev_rise,
  output logic     stretched
);

  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYCLES);

  logic [NUM_EV-1:0] ev_now, ev_prev;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_live;

  assign ev_now    = event_terms(ctrl, stat);
  assign ev_rise   = |(ev_now & ~ev_prev);
  assign raw_or    = level_or(ctrl, stat) | (|ev_now);
  assign cnt_live  = (cnt != '0);
  assign stretched = raw_or | (ctrl.pse & cnt_live);

  always_ff @(posedge clk) begin
    if (hrst) begin
      ev_prev <= '0;
      cnt     <= '0;
    end else begin
      ev_prev <= ev_now;
      if (!ctrl.pse)    cnt <= '0;
      else if (ev_rise) cnt <= CNT_LOAD;
      else if (cnt_live) cnt <= cnt - 1'b1;
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (hrst)
    cnt <= CNT_LOAD);

  a_r5_reload: assert property (@(posedge clk) disable iff (hrst)
    (ctrl.pse && ev_rise) |=> (cnt == CNT_LOAD));

  a_r5_count_down: assert property (@(posedge clk) disable iff (hrst)
    (ctrl.pse && !ev_rise && cnt_live) |=> (cnt == $past(cnt) - 1'b1));

  a_r6_held_zero: assert property (@(posedge clk) disable iff (hrst)
    !ctrl.pse |=> (cnt == '0));

endmodule

// File: rtl/led_ind_drive.sv
module led_ind_drive
  import led_ind_pkg::*;
(
  input  logic clk,
  input  logic hrst,
  input  logic dis,
  input  logic pol,
  input  logic active,
  output logic led_pin
);

  always_ff @(posedge clk) begin
    if (hrst) led_pin <= pin_level(CTRL_RST.dis, CTRL_RST.pol, 1'b0);
    else      led_pin <= pin_level(dis, pol, active);
  end

  a_r1_disable_forces_off: assert property (@(posedge clk) disable iff (hrst)
    dis |=> (led_pin == ~$past(pol)));

  a_r2_active_level: assert property (@(posedge clk) disable iff (hrst)
    (active && !dis) |=> (led_pin == $past(pol)));

endmodule

// File: rtl/led_status_ind.sv
module led_status_ind
  import led_ind_pkg::*;
#(
  parameter int STRETCH_CYCLES = 16
)(
  input  logic        clk,
  input  logic        hrst,
  input  logic        srst,
  input  logic        stop,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        st_100m,
  input  logic        st_mp_mode,
  input  logic        st_mp_det,
  input  logic        st_link,
  input  logic        st_fdx,
  input  logic        st_rx_match,
  input  logic        st_tx,
  output logic        led_pin
);

  ctrl_t    ctrl_q;
  stat_in_t stat;
  logic     raw_or, ev_rise, stretched;

  assign stat = '{spd: st_100m, mp_mode: st_mp_mode, mp_det: st_mp_det,
                  link: st_link, fdx: st_fdx, rx_match: st_rx_match, tx: st_tx};

  led_ind_regs u_regs (
    .clk(clk), .hrst(hrst), .srst(srst), .stop(stop),
    .we(reg_we), .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  led_ind_src #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_src (
    .clk(clk), .hrst(hrst), .ctrl(ctrl_q), .stat(stat),
    .raw_or(raw_or), .ev_rise(ev_rise), .stretched(stretched)
  );

  led_ind_drive u_drive (
    .clk(clk), .hrst(hrst), .dis(ctrl_q.dis), .pol(ctrl_q.pol),
    .active(stretched), .led_pin(led_pin)
  );

  assign reg_rdata = ctrl_to_word(ctrl_q, stretched);

  a_r7_status_covers_raw: assert property (@(posedge clk) disable iff (hrst)
    raw_or |-> reg_rdata[15]);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (hrst)
    (reg_rdata[11:10] == 2'b00) && (reg_rdata[3:0] == 4'b0000));

  a_r5_rise_sets_status: assert property (@(posedge clk) disable iff (hrst)
    (ev_rise && ctrl_q.pse) |=> reg_rdata[15]);

endmodule

// File: tb/led_status_ind_test.sv
`timescale 1ns/1ps
module led_status_ind_test;

  localparam int STRETCH = 16;

  logic clk = 1'b0;
  logic hrst = 1'b1, srst = 1'b0, stop = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic st_100m = 0, st_mp_mode = 0, st_mp_det = 0, st_link = 0, st_fdx = 0;
  logic st_rx_match = 0, st_tx = 0;
  logic led_pin;

  always #2 clk = ~clk;

  led_status_ind #(.STRETCH_CYCLES(STRETCH)) uut (
    .clk(clk), .hrst(hrst), .srst(srst), .stop(stop),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_100m(st_100m), .st_mp_mode(st_mp_mode), .st_mp_det(st_mp_det),
    .st_link(st_link), .st_fdx(st_fdx), .st_rx_match(st_rx_match),
    .st_tx(st_tx), .led_pin(led_pin)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  string cur_req = "R9";
  bit chk_en = 0, done = 0;

  // Reference model state
  logic [15:0] m_ctrl = 16'h0080;
  int m_hold = 0;
  bit m_pm = 0, m_pr = 0, m_pt = 0;
  bit m_pin = 1;

  function automatic bit m_raw(input logic [15:0] c);
    bit r;
    r = 0;
    if (c[12] && st_100m) r = 1;
    if (c[9] && st_mp_mode && st_mp_det) r = 1;
    if (c[8] && st_link && st_fdx) r = 1;
    if (c[6] && st_link) r = 1;
    if (c[5] && st_rx_match) r = 1;
    if (c[4] && st_tx) r = 1;
    return r;
  endfunction

  function automatic bit m_status();
    return m_raw(m_ctrl) || (m_ctrl[7] && m_hold > 0);
  endfunction

  always @(posedge clk) begin
    if (hrst) begin
      m_ctrl = 16'h0080; m_hold = 0; m_pm = 0; m_pr = 0; m_pt = 0; m_pin = 1;
    end else begin
      bit st, em, er, et;
      st = m_status();
      m_pin = (st && !m_ctrl[13]) ? m_ctrl[14] : !m_ctrl[14];
      em = m_ctrl[9] && st_mp_mode && st_mp_det;
      er = m_ctrl[5] && st_rx_match;
      et = m_ctrl[4] && st_tx;
      if (!m_ctrl[7]) m_hold = 0;
      else if ((em && !m_pm) || (er && !m_pr) || (et && !m_pt)) m_hold = STRETCH;
      else if (m_hold > 0) m_hold = m_hold - 1;
      m_pm = em; m_pr = er; m_pt = et;
      if (reg_we) m_ctrl = reg_wdata & 16'h73F0;
    end
  end

  always @(posedge clk) begin
    #1;
    if (chk_en && !done) begin
      logic [15:0] exp_rd;
      exp_rd = m_ctrl | {m_status(), 15'b0};
      compared++;
      if (reg_rdata !== exp_rd) begin
        mismatched++;
        $display("FAIL %s reg_rdata actual=%h expected=%h t=%0t",
                 (reg_rdata[15] !== exp_rd[15]) ? "R7" : cur_req, reg_rdata, exp_rd, $time);
      end
      compared++;
      if (led_pin !== m_pin) begin
        mismatched++;
        $display("FAIL %s R12 led_pin actual=%b expected=%b t=%0t",
                 cur_req, led_pin, m_pin, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<50000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    reg_we = 1; reg_wdata = v;
    step(1);
    reg_we = 0; reg_wdata = '0;
  endtask

  initial begin
    step(3);
    chk_en = 1;
    step(1);
    hrst = 0;
    cur_req = "R9"; step(3);            // reset value 0x0080, pin 1

    cur_req = "R8"; wr(16'hFFFF); step(2);   // reserved bits stay zero
    cur_req = "R11"; wr(16'h0000); step(2);

    cur_req = "R2"; wr(16'h4040); st_link = 1; step(3);
    wr(16'h0040); step(3);
    st_link = 0; step(2);

    cur_req = "R3";
    wr(16'h1000); st_100m = 1; step(2); st_100m = 0; step(2);
    wr(16'h0200); st_mp_mode = 1; step(2); st_mp_det = 1; step(2);
    st_mp_mode = 0; st_mp_det = 0; step(2);
    wr(16'h0020); st_rx_match = 1; step(2); st_rx_match = 0; step(2);
    wr(16'h0010); st_tx = 1; step(2); st_tx = 0; step(2);
    wr(16'h0040); st_link = 1; step(2); st_link = 0; step(2);

    cur_req = "R4"; wr(16'h0100);
    st_link = 1; step(2); st_link = 0; st_fdx = 1; step(2);
    st_link = 1; step(3); st_link = 0; st_fdx = 0; step(2);

    cur_req = "R5"; wr(16'h0090);
    st_tx = 1; step(1); st_tx = 0; step(8);
    st_tx = 1; step(1); st_tx = 0; step(25);
    st_tx = 1; step(5); st_tx = 0; step(25);
    wr(16'h02B0); st_mp_mode = 1; st_mp_det = 1; step(1);
    st_mp_det = 0; step(4); st_rx_match = 1; step(1); st_rx_match = 0; step(22);
    st_mp_mode = 0;
    wr(16'h10C0); st_link = 1; step(2); st_link = 0; step(4);

    cur_req = "R6"; wr(16'h0010);
    st_tx = 1; step(1); st_tx = 0; step(3);
    wr(16'h0090); st_tx = 1; step(1); st_tx = 0; step(3);
    wr(16'h0010); step(4);

    cur_req = "R7"; wr(16'h6020); st_rx_match = 1; step(3); st_rx_match = 0; step(2);

    cur_req = "R1"; wr(16'h0040); st_link = 1; step(2);
    wr(16'h2040); step(3); wr(16'h6040); step(3);
    wr(16'h4040); step(3); st_link = 0; step(1);

    cur_req = "R10"; wr(16'h4250); st_tx = 1; step(1); st_tx = 0;
    srst = 1; step(1); srst = 0; step(2);
    stop = 1; st_tx = 1; step(1); st_tx = 0; step(5); stop = 0;
    srst = 1; wr(16'h0040); srst = 0; step(3);

    cur_req = "R9"; hrst = 1; step(2); hrst = 0; step(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule